// File: doc/BRIEF.md
# Chunk Hamming Parity Accumulator

The block watches a byte stream on its way to or from a NAND array and builds a single-error-correcting Hamming parity over every 256-byte chunk of that stream. It folds each accepted byte into a running set of line terms and column terms. The line terms are indexed by the byte's position inside the chunk. The column terms are indexed by bit position inside the byte. When the last byte of a chunk arrives, it publishes the finished parity word together with the chunk's number in the page. It also publishes the 3-byte form that is written to the spare area. The accumulator then starts on the next chunk without any help from outside.

The same logic serves writes and reads. On a write, the published code goes into the spare area. On a read, the freshly computed word is given to the built-in checker together with the 3 spare bytes read back from the device. The checker is purely combinational. Its verdict is one of four: the chunk is clean, one data bit is wrong (and where it is), the stored code itself took the hit, or the damage is beyond repair. A clear pulse wipes all partial state before a new page, and accumulation happens only while the enable input is high.

Top module: `eccChunkParity`

## Requirements
- R1: While reset is asserted and after its release, resultValid is 0, resultWord is 0 and resultIdx is 0, until a chunk completes.
- R2: A byte is accepted only in a cycle where inValid and eccEn are both 1 and clear is 0. Any other cycle leaves the byte count and the parity unchanged.
- R3: resultValid is a one-cycle pulse. It appears in the cycle after the 256th accepted byte of a chunk and never before it. The next accepted byte begins a new chunk from zero.
- R4: Column parity sits in resultWord[5:0]. For j = 0..2, bit 2j+1 is the XOR of every data bit of the chunk whose bit position has bit j set, and bit 2j is the XOR of those whose bit position has bit j clear.
- R5: Line parity sits in resultWord[21:6]. For k = 0..7, bit 6+2k+1 is the XOR of every data bit in bytes whose chunk index has bit k set, and bit 6+2k is the XOR of those in bytes whose index has bit k clear.
- R6: resultCode equals the low 24 bits of the bitwise inverse of resultWord shifted left by two. resultCode[23:16] is the first spare byte, [15:8] the second and [7:0] the third.
- R7: A clear pulse zeroes the byte count, the partial parity and the chunk number. A byte offered in the same cycle as clear is dropped.
- R8: resultIdx numbers the chunks completed since the last clear, from 0 upward, and wraps after 16.
- R9: The checker decodes the stored code as the inverse of chkStored[23:2], so chkStored[1:0] is ignored. If the decoded value matches chkCalc, chkVerdict is 0 and chkByte and chkBit are 0.
- R10: If every one of the 11 bit pairs of the syndrome (decoded stored XOR chkCalc) has exactly one bit set, chkVerdict is 1. chkByte is then formed from the odd bits of the line pairs and chkBit from the odd bits of the column pairs.
- R11: If the syndrome has exactly one bit set, chkVerdict is 2 (code corrupted) and the location outputs are 0.
- R12: Any other non-zero syndrome gives chkVerdict 3 (uncorrectable) with the location outputs at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| eccEn | input | 1 | Accumulation enable |
| clear | input | 1 | Wipe partial parity, byte count and chunk number |
| inValid | input | 1 | inByte carries a stream byte this cycle |
| inByte | input | 8 | Stream byte |
| resultValid | output | 1 | One-cycle strobe for a finished chunk |
| resultWord | output | 22 | Line parity [21:6], column parity [5:0] |
| resultCode | output | 24 | Spare-area form, first byte in [23:16] |
| resultIdx | output | 4 | Chunk number within the page |
| chkStored | input | 24 | Three spare bytes read back, first in [23:16] |
| chkCalc | input | 22 | Parity word computed on read |
| chkVerdict | output | 2 | 0 clean, 1 data bit fixed, 2 code hit, 3 uncorrectable |
| chkByte | output | 8 | Index of the faulty byte when verdict is 1 |
| chkBit | output | 3 | Position of the faulty bit when verdict is 1 |

## Verification
The embedded properties cover the framing on every cycle. They check that the byte count holds whenever no byte is taken and returns to zero after a clear. They check that the result strobe never lasts two cycles and that the partial parity is empty while it is high. They also check that a repair verdict always rests on a syndrome of weight eleven. The actual parity values, the spare-byte packing, the chunk numbering across a full page and its wrap, and the checker's verdicts for flipped data bits, flipped code bits and double errors can only be shown by the bench. It does so by comparing against a bit-by-bit model of the parity definition.

// File: rtl/eccPkg.sv
package eccPkg;

  localparam int COL_W = 6;

  typedef struct packed {
    logic take;
    logic last;
    logic wipe;
  } eccStrobe_t;

  typedef enum logic [1:0] {
    VERD_CLEAN = 2'd0,
    VERD_FIX   = 2'd1,
    VERD_CODE  = 2'd2,
    VERD_MULTI = 2'd3
  } verdict_t;

endpackage

// File: rtl/eccCtrl.sv
module eccCtrl
  import eccPkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             eccEn,
  input  logic             clear,
  input  logic             inValid,
  output eccStrobe_t       strb,
  output logic [IDX_W-1:0] byteIdx
);

  logic [IDX_W-1:0] byteCnt;

  always_comb begin
    strb.wipe = clear;
    strb.take = inValid & eccEn & ~clear;
    strb.last = strb.take & (&byteCnt);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          byteCnt <= '0;
    else if (strb.wipe) byteCnt <= '0;
    else if (strb.take) byteCnt <= byteCnt + 1'b1;
  end

  assign byteIdx = byteCnt;

  assert_count_zero_after_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> (byteCnt == '0));

  assert_count_holds_when_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!inValid || !eccEn || clear) && !clear |=> $stable(byteCnt));

endmodule

// File: rtl/eccDatapath.sv
module eccDatapath
  import eccPkg::*;
#(
  parameter int IDX_W       = 8,
  parameter int CHUNK_IDX_W = 4,
  localparam int LINE_W     = 2 * IDX_W,
  localparam int RES_W      = LINE_W + COL_W,
  localparam int CODE_W     = RES_W + 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  eccStrobe_t             strb,
  input  logic [IDX_W-1:0]       byteIdx,
  input  logic [7:0]             inByte,
  output logic                   resultValid,
  output logic [RES_W-1:0]       resultWord,
  output logic [CODE_W-1:0]      resultCode,
  output logic [CHUNK_IDX_W-1:0] resultIdx
);

  logic [RES_W-1:0]       acc;
  logic [RES_W-1:0]       contrib;
  logic [CHUNK_IDX_W-1:0] chunkCnt;
  logic                   bytePar;

  // one byte's share: line terms reuse the byte parity, column terms split bits
  always_comb begin
    contrib = '0;
    bytePar = ^inByte;
    for (int k = 0; k < IDX_W; k++) begin
      contrib[COL_W + 2*k]     = bytePar & ~byteIdx[k];
      contrib[COL_W + 2*k + 1] = bytePar &  byteIdx[k];
    end
    for (int j = 0; j < 3; j++) begin
      for (int b = 0; b < 8; b++) begin
        if (((b >> j) & 1) == 1) contrib[2*j + 1] = contrib[2*j + 1] ^ inByte[b];
        else                     contrib[2*j]     = contrib[2*j]     ^ inByte[b];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc         <= '0;
      resultWord  <= '0;
      resultValid <= 1'b0;
      resultIdx   <= '0;
      chunkCnt    <= '0;
    end else begin
      resultValid <= strb.last;
      if (strb.wipe) begin
        acc      <= '0;
        chunkCnt <= '0;
      end else if (strb.last) begin
        resultWord <= acc ^ contrib;
        resultIdx  <= chunkCnt;
        chunkCnt   <= chunkCnt + 1'b1;
        acc        <= '0;
      end else if (strb.take) begin
        acc <= acc ^ contrib;
      end
    end
  end

  assign resultCode = ~{resultWord, 2'b00};

  assert_valid_single_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  assert_acc_empty_at_result_R3: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> (acc == '0));

endmodule

// File: rtl/eccCorrector.sv
module eccCorrector
  import eccPkg::*;
#(
  parameter int IDX_W   = 8,
  localparam int RES_W  = 2 * IDX_W + COL_W,
  localparam int CODE_W = RES_W + 2,
  localparam int PAIRS  = RES_W / 2
) (
  input  logic [CODE_W-1:0] storedCode,
  input  logic [RES_W-1:0]  calcWord,
  output verdict_t          verdict,
  output logic [IDX_W-1:0]  fixByte,
  output logic [2:0]        fixBit
);

  logic [RES_W-1:0] syn;
  logic             pairsOk;

  always_comb begin
    syn     = ~storedCode[CODE_W-1:2] ^ calcWord;
    pairsOk = 1'b1;
    for (int m = 0; m < PAIRS; m++) pairsOk = pairsOk & (syn[2*m] ^ syn[2*m + 1]);
    fixByte = '0;
    fixBit  = '0;
    if (syn == '0) begin
      verdict = VERD_CLEAN;
    end else if (pairsOk) begin
      verdict = VERD_FIX;
      for (int k = 0; k < IDX_W; k++) fixByte[k] = syn[COL_W + 2*k + 1];
      for (int j = 0; j < 3; j++)     fixBit[j]  = syn[2*j + 1];
    end else if ($countones(syn) == 1) begin
      verdict = VERD_CODE;
    end else begin
      verdict = VERD_MULTI;
    end
  end

  always_comb begin
    if (verdict == VERD_FIX)
      assert_fix_weight_R10: assert ($countones(syn) == PAIRS);
  end

endmodule

// File: rtl/eccChunkParity.sv
module eccChunkParity
  import eccPkg::*;
#(
  parameter int BYTE_IDX_W   = 8,
  parameter int PAGE_CHUNKS  = 16,
  localparam int RES_W       = 2 * BYTE_IDX_W + COL_W,
  localparam int CODE_W      = RES_W + 2,
  localparam int CHUNK_IDX_W = $clog2(PAGE_CHUNKS)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   eccEn,
  input  logic                   clear,
  input  logic                   inValid,
  input  logic [7:0]             inByte,
  output logic                   resultValid,
  output logic [RES_W-1:0]       resultWord,
  output logic [CODE_W-1:0]      resultCode,
  output logic [CHUNK_IDX_W-1:0] resultIdx,
  input  logic [CODE_W-1:0]      chkStored,
  input  logic [RES_W-1:0]       chkCalc,
  output logic [1:0]             chkVerdict,
  output logic [BYTE_IDX_W-1:0]  chkByte,
  output logic [2:0]             chkBit
);

  eccStrobe_t            strb;
  logic [BYTE_IDX_W-1:0] byteIdx;
  verdict_t              verdict;

  eccCtrl #(.IDX_W(BYTE_IDX_W)) uCtrl (
    .clk(clk), .rstN(rstN), .eccEn(eccEn), .clear(clear),
    .inValid(inValid), .strb(strb), .byteIdx(byteIdx)
  );

  eccDatapath #(.IDX_W(BYTE_IDX_W), .CHUNK_IDX_W(CHUNK_IDX_W)) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .byteIdx(byteIdx), .inByte(inByte),
    .resultValid(resultValid), .resultWord(resultWord),
    .resultCode(resultCode), .resultIdx(resultIdx)
  );

  eccCorrector #(.IDX_W(BYTE_IDX_W)) uFix (
    .storedCode(chkStored), .calcWord(chkCalc),
    .verdict(verdict), .fixByte(chkByte), .fixBit(chkBit)
  );

  assign chkVerdict = verdict;

endmodule

// File: tb/sim_eccChunkParity.sv
module sim_eccChunkParity;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        eccEn = 1'b0, clear = 1'b0, inValid = 1'b0;
  logic [7:0]  inByte = '0;
  logic        resultValid;
  logic [21:0] resultWord;
  logic [23:0] resultCode;
  logic [3:0]  resultIdx;
  logic [23:0] chkStored = '0;
  logic [21:0] chkCalc = '0;
  logic [1:0]  chkVerdict;
  logic [7:0]  chkByte;
  logic [2:0]  chkBit;

  int nTests = 0, nFail = 0;
  int expIdx = 0;
  logic [7:0] chunkData [256];

  always #10 clk = ~clk;

  eccChunkParity u0 (
    .clk(clk), .rstN(rstN), .eccEn(eccEn), .clear(clear), .inValid(inValid),
    .inByte(inByte), .resultValid(resultValid), .resultWord(resultWord),
    .resultCode(resultCode), .resultIdx(resultIdx), .chkStored(chkStored),
    .chkCalc(chkCalc), .chkVerdict(chkVerdict), .chkByte(chkByte), .chkBit(chkBit)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bit-by-bit model of the parity definition (R4, R5)
  function automatic logic [21:0] refWord();
    logic [21:0] w = '0;
    for (int i = 0; i < 256; i++)
      for (int b = 0; b < 8; b++)
        if (chunkData[i][b]) begin
          for (int k = 0; k < 8; k++) w[6 + 2*k + ((i >> k) & 1)] ^= 1'b1;
          for (int j = 0; j < 3; j++) w[2*j + ((b >> j) & 1)] ^= 1'b1;
        end
    return w;
  endfunction

  function automatic logic [23:0] pack(input logic [21:0] w);
    return ~{w, 2'b00};
  endfunction

  task automatic fillSeed(input logic [15:0] seed);
    logic [15:0] s = seed;
    for (int i = 0; i < 256; i++) begin
      s = {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
      chunkData[i] = s[7:0] ^ s[15:8];
    end
  endtask

  task automatic fillConst(input logic [7:0] v);
    for (int i = 0; i < 256; i++) chunkData[i] = v;
  endtask

  // sends one chunk and checks the strobe timing, word, code and number
  task automatic feedChunk(input string tag);
    logic [21:0] w = refWord();
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      if (i == 255) check(resultValid == 1'b0, {tag, " R3 early strobe"}, resultValid, 0);
      inValid = 1'b1; inByte = chunkData[i];
    end
    @(negedge clk);
    inValid = 1'b0;
    check(resultValid == 1'b1, {tag, " R3 strobe"}, resultValid, 1);
    check(resultWord == w, {tag, " R4 R5 word"}, resultWord, w);
    check(resultCode == pack(w), {tag, " R6 code"}, resultCode, pack(w));
    check(resultIdx == expIdx[3:0], {tag, " R8 index"}, resultIdx, expIdx[3:0]);
    expIdx = (expIdx + 1) % 16;
    @(negedge clk);
    check(resultValid == 1'b0, {tag, " R3 pulse width"}, resultValid, 0);
  endtask

  task automatic doClear();
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
    expIdx = 0;
  endtask

  task automatic testReset();
    check(resultValid == 0 && resultWord == 0 && resultIdx == 0, "R1 reset state",
          {resultValid, resultIdx, resultWord}, 0);
  endtask

  task automatic testPatterns();
    fillConst(8'h00); feedChunk("zeros");
    check(resultCode == 24'hFFFFFF, "R6 zero chunk code", resultCode, 24'hFFFFFF);
    fillConst(8'h00); chunkData[8'hA5] = 8'h08; feedChunk("single bit");
    fillConst(8'hFF); feedChunk("all ones");
    fillSeed(16'hACE1); feedChunk("lfsr");
  endtask

  task automatic testPage();
    doClear();
    for (int c = 0; c < 17; c++) begin
      fillSeed(16'h1234 + 16'(c * 97));
      feedChunk("page R8");
    end
  endtask

  task automatic testEnable();
    logic [21:0] w;
    doClear();
    fillSeed(16'h5EED);
    w = refWord();
    for (int i = 0; i < 256; i++) begin
      @(negedge clk); eccEn = 1'b0; inValid = 1'b1; inByte = 8'hFF;
      @(negedge clk); eccEn = 1'b1; inValid = 1'b0; inByte = 8'h3C;
      @(negedge clk); inValid = 1'b1; inByte = chunkData[i];
    end
    @(negedge clk); inValid = 1'b0;
    check(resultValid == 1'b1, "R2 strobe after gated bytes", resultValid, 1);
    check(resultWord == w, "R2 gated bytes ignored", resultWord, w);
    expIdx = 1;
  endtask

  task automatic testClear();
    doClear();
    for (int i = 0; i < 100; i++) begin
      @(negedge clk); inValid = 1'b1; inByte = 8'(i * 7 + 1);
    end
    @(negedge clk); clear = 1'b1; inValid = 1'b1; inByte = 8'hFF;
    @(negedge clk); clear = 1'b0; inValid = 1'b0;
    expIdx = 0;
    fillSeed(16'hBEEF);
    feedChunk("R7 after clear");
  endtask

  task automatic setChk(input logic [23:0] s, input logic [21:0] c);
    @(negedge clk); chkStored = s; chkCalc = c; #1;
  endtask

  task automatic flipCheck(input int i, input int b);
    logic [21:0] w0, w1;
    w0 = refWord();
    chunkData[i][b] = ~chunkData[i][b];
    w1 = refWord();
    chunkData[i][b] = ~chunkData[i][b];
    setChk(pack(w0), w1);
    check(chkVerdict == 2'd1, "R10 verdict", chkVerdict, 1);
    check(chkByte == 8'(i) && chkBit == 3'(b), "R10 location", {chkByte, chkBit}, {8'(i), 3'(b)});
  endtask

  task automatic testCorrector();
    logic [21:0] w0, w1;
    fillSeed(16'h7777);
    w0 = refWord();
    setChk(pack(w0), w0);
    check(chkVerdict == 2'd0 && chkByte == 0 && chkBit == 0, "R9 clean", chkVerdict, 0);
    setChk(pack(w0) & 24'hFFFFFC, w0);
    check(chkVerdict == 2'd0, "R9 low bits ignored", chkVerdict, 0);
    flipCheck(8'h3C, 6);
    flipCheck(255, 7);
    flipCheck(0, 0);
    setChk(pack(w0) ^ 24'h000400, w0);
    check(chkVerdict == 2'd2 && chkByte == 0 && chkBit == 0, "R11 code bit hit", chkVerdict, 2);
    chunkData[5][1] = ~chunkData[5][1];
    chunkData[9][1] = ~chunkData[9][1];
    w1 = refWord();
    setChk(pack(w0), w1);
    check(chkVerdict == 2'd3 && chkByte == 0 && chkBit == 0, "R12 double error", chkVerdict, 3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nTests++; nFail++;
    $display("FAIL watchdog expired (all requirements) actual=hang expected=done");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    eccEn = 1'b1;
    testPatterns();
    testPage();
    testEnable();
    testClear();
    testCorrector();
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule